// File: doc/BRIEF.md
# Prioritizing Interrupt Controller

This block gathers a bank of interrupt request lines, from pins and from on-chip peripherals, and hands the processor core one winning request at a time. Each input passes through a two-stage synchronizer. It is then sensed according to a per-source mode: active-high level, active-low level, rising edge or falling edge. For an edge source, the controller holds a pending flag until software clears it. For a level source, the pending state tracks the input.

Software sets each source through a small write port. One write selects a source index and loads that source's 2-bit sense mode and 3-bit priority level. A priority of zero turns the source off. Edge requests are removed by writing an encoded source number to the clear port. Source index i uses code i+1, so code 1 names the first source and code 0 names none.

The core supplies a global enable and its current mask level. The controller registers a request flag, the winning level and the winning source code.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset behaviour.
  - While and after reset, `irq_req`, `irq_lvl` and `irq_id` are 0.
  - Every source comes out of reset with priority 0 (off) and sense mode 01.
- R2: In sense mode 01, a source is pending while its input is 1.
- R3: In sense mode 00, a source is pending while its input is 0.
- R4: Sense mode 10 latches a pending request on a 0-to-1 transition of the synchronized input. The request stays pending after the input returns to 0, until it is cleared.
- R5: Sense mode 11 latches a pending request on a 1-to-0 transition. It holds the request the same way as R4.
- R6: A clear write affects only the matching edge source.
  - A clear write with code i+1 removes the latched edge request of source index i.
  - Codes 0 and codes of other sources leave that request pending.
- R7: A clear write has no effect on a level-sensed source whose input is still active.
- R8: A source with priority 0 is never presented, even while its input is active.
- R9: Arbitration among presentable sources.
  - Of all pending sources with nonzero priority, the one with the highest priority is presented.
  - `irq_id` is its code (index+1).
  - On equal priority, the lower index wins.
- R10: Delivery gating.
  - `irq_req` is 1 only when `glb_en` is 1 and the winning priority is strictly greater than `mask_lvl`.
  - Otherwise `irq_req`, `irq_lvl` and `irq_id` are all 0.
- R11: The outputs are registered. A change on `glb_en` or `mask_lvl` shows on the outputs after exactly one rising clock edge.
- R12: If an edge is detected in the same cycle as a clear write for that source, the request stays pending.
- R13: A configuration write replaces both the mode and the priority of the source selected by `cfg_idx` (0-based). All other sources keep their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Raw request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | clog2(NSRC) | Source index to configure |
| cfg_mode | input | 2 | Sense mode: 00 low, 01 high, 10 rise, 11 fall |
| cfg_level | input | 3 | Priority level, 0 disables |
| clr_we | input | 1 | Clear write strobe |
| clr_code | input | 6 | Encoded source to clear (index+1) |
| glb_en | input | 1 | Processor global interrupt enable |
| mask_lvl | input | 3 | Processor current mask level |
| irq_req | output | 1 | Request to the core |
| irq_lvl | output | 3 | Priority of the presented request |
| irq_id | output | 6 | Code of the presented source, 0 when idle |

## Verification
The delicate overlap is a new edge being captured in the very cycle that software writes the clear code for the same source. The bench places the clear strobe on the exact clock edge where the synchronized transition reaches the edge latch, counting the two synchronizer stages. It then confirms that the request remains presented (set wins). A second clear afterwards must remove it, which shows that the clear path itself works.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int ID_W  = 6;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_in;
    for (int k = 1; k < STAGES; k++) chain_d[k] = chain_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_in,
  input  logic             cfg_wr,
  input  sense_e           cfg_mode,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             clr_hit,
  output logic             pend_o,
  output logic [LVL_W-1:0] lvl_o
);
  sense_e           mode_q, mode_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             prev_q;
  logic             edge_q, edge_d;
  logic             is_edge, edge_now;

  always_comb begin
    mode_d = mode_q;
    lvl_d  = lvl_q;
    if (cfg_wr) begin
      mode_d = cfg_mode;
      lvl_d  = cfg_level;
    end
  end

  always_comb begin
    is_edge  = (mode_q == SENSE_RISE) || (mode_q == SENSE_FALL);
    edge_now = (mode_q == SENSE_RISE) ? (s_in & ~prev_q)
             : (mode_q == SENSE_FALL) ? (~s_in & prev_q) : 1'b0;
    edge_d   = is_edge ? (edge_now | (edge_q & ~clr_hit)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SENSE_HIGH;
      lvl_q  <= '0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
      prev_q <= s_in;
      edge_q <= edge_d;
    end
  end

  always_comb begin
    case (mode_q)
      SENSE_HIGH: pend_o = s_in;
      SENSE_LOW:  pend_o = ~s_in;
      default:    pend_o = edge_q;
    endcase
  end
  assign lvl_o = lvl_q;

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && !cfg_wr) |=> pend_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && clr_hit && !edge_now && !cfg_wr) |=> !pend_o);
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && edge_q && !clr_hit && !cfg_wr) |=> pend_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][LVL_W-1:0] lvls,
  input  logic                       glb_en,
  input  logic [LVL_W-1:0]           mask_lvl,
  output logic                       irq_req,
  output logic [LVL_W-1:0]           irq_lvl,
  output logic [ID_W-1:0]            irq_id
);
  logic [LVL_W-1:0] best_lvl;
  logic [ID_W-1:0]  best_id;
  logic             fire;
  logic             req_d;
  logic [LVL_W-1:0] lvl_d;
  logic [ID_W-1:0]  id_d;

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (lvls[i] > best_lvl)) begin
        best_lvl = lvls[i];
        best_id  = ID_W'(i + 1);
      end
    end
    fire  = glb_en && (best_lvl > mask_lvl);
    req_d = fire;
    lvl_d = fire ? best_lvl : '0;
    id_d  = fire ? best_id  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_lvl <= '0;
      irq_id  <= '0;
    end else begin
      irq_req <= req_d;
      irq_lvl <= lvl_d;
      irq_id  <= id_d;
    end
  end

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(glb_en) && (irq_lvl > $past(mask_lvl))));
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_lvl == '0 && irq_id == '0));
  p_id_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_id != '0 && irq_id <= ID_W'(NSRC)));
  p_nonzero_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl != '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_mode,
  input  logic [2:0]       cfg_level,
  input  logic             clr_we,
  input  logic [5:0]       clr_code,
  input  logic             glb_en,
  input  logic [2:0]       mask_lvl,
  output logic             irq_req,
  output logic [2:0]       irq_lvl,
  output logic [5:0]       irq_id
);
  logic [NSRC-1:0]            synced;
  logic [NSRC-1:0]            pend;
  logic [NSRC-1:0][LVL_W-1:0] lvls;

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (irq_in),
    .q_out (synced)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    logic wr_sel;
    logic clr_sel;
    assign wr_sel  = cfg_we && (cfg_idx == IDX_W'(g));
    assign clr_sel = clr_we && (clr_code == ID_W'(g + 1));
    irq_src_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_in      (synced[g]),
      .cfg_wr    (wr_sel),
      .cfg_mode  (sense_e'(cfg_mode)),
      .cfg_level (cfg_level),
      .clr_hit   (clr_sel),
      .pend_o    (pend[g]),
      .lvl_o     (lvls[g])
    );
  end

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .lvls     (lvls),
    .glb_en   (glb_en),
    .mask_lvl (mask_lvl),
    .irq_req  (irq_req),
    .irq_lvl  (irq_lvl),
    .irq_id   (irq_id)
  );
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [N-1:0] irq_in;
  logic       cfg_we;
  logic [2:0] cfg_idx;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_level;
  logic       clr_we;
  logic [5:0] clr_code;
  logic       glb_en;
  logic [2:0] mask_lvl;
  logic       irq_req;
  logic [2:0] irq_lvl;
  logic [5:0] irq_id;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NSRC(N)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode), .cfg_level(cfg_level),
    .clr_we(clr_we), .clr_code(clr_code), .glb_en(glb_en), .mask_lvl(mask_lvl),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_id(irq_id)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {req,lvl,id}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pack(input logic r, input logic [2:0] l, input logic [5:0] id);
    return {r, l, id};
  endfunction

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int idx, input logic [1:0] m, input logic [2:0] l);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_mode = m; cfg_level = l;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr(input logic [5:0] code);
    clr_we = 1'b1; clr_code = code;
    @(posedge clk); @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic all_off();
    for (int i = 0; i < N; i++) cfg(i, 2'b01, 3'd0);
  endtask

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; cfg_we = 0; cfg_idx = 0; cfg_mode = 0; cfg_level = 0;
    clr_we = 0; clr_code = 0; glb_en = 1'b1; mask_lvl = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 during reset", {irq_req, irq_lvl, irq_id}, 10'd0);
    rst_n = 1'b1;
    irq_in = '1;
    settle();
    // R1: all sources start disabled
    check("R1 defaults disabled", {irq_req, irq_lvl, irq_id}, 10'd0);
    // R1/R13: giving source 3 a level with default mode 01 shows it at high input
    cfg_we = 1'b1; cfg_idx = 3'd3; cfg_mode = 2'b01; cfg_level = 3'd2;
    @(posedge clk); @(negedge clk); cfg_we = 0;
    settle();
    check("R1 default mode high", {irq_req, irq_lvl, irq_id}, pack(1, 3'd2, 6'd4));
    all_off();
    irq_in = '0;
    settle();

    // Per-source, per-mode sweep
    for (int i = 0; i < N; i++) begin
      logic [2:0] l;
      l = 3'((i % 7) + 1);
      // R2 high level
      cfg(i, 2'b01, l);
      irq_in = N'(1) << i; settle();
      check("R2 high active", {irq_req, irq_lvl, irq_id}, pack(1, l, 6'(i + 1)));
      irq_in = '0; settle();
      check("R2 high inactive", {irq_req, irq_lvl, irq_id}, 10'd0);
      // R3 low level
      cfg(i, 2'b00, l); settle();
      check("R3 low active", {irq_req, irq_lvl, irq_id}, pack(1, l, 6'(i + 1)));
      irq_in = N'(1) << i; settle();
      check("R3 low inactive", {irq_req, irq_lvl, irq_id}, 10'd0);
      // R4 rising edge
      irq_in = '0; cfg(i, 2'b10, l); settle();
      clr(6'(i + 1)); settle();
      check("R4 rise idle", {irq_req, irq_lvl, irq_id}, 10'd0);
      irq_in = N'(1) << i; settle();
      irq_in = '0; settle();
      check("R4 rise held", {irq_req, irq_lvl, irq_id}, pack(1, l, 6'(i + 1)));
      clr(6'(i + 1)); settle();
      check("R6 rise cleared", {irq_req, irq_lvl, irq_id}, 10'd0);
      // R5 falling edge
      irq_in = N'(1) << i; cfg(i, 2'b11, l); settle();
      check("R5 fall idle", {irq_req, irq_lvl, irq_id}, 10'd0);
      irq_in = '0; settle();
      irq_in = N'(1) << i; settle();
      check("R5 fall held", {irq_req, irq_lvl, irq_id}, pack(1, l, 6'(i + 1)));
      clr(6'(i + 1)); settle();
      check("R6 fall cleared", {irq_req, irq_lvl, irq_id}, 10'd0);
      irq_in = '0;
      cfg(i, 2'b01, 3'd0); settle();
    end

    // R6: wrong codes leave the latch alone
    cfg(2, 2'b10, 3'd6);
    irq_in = N'(1) << 2; settle(); irq_in = '0; settle();
    clr(6'd0); clr(6'd4); clr(6'd2); settle();
    check("R6 other codes ignored", {irq_req, irq_lvl, irq_id}, pack(1, 3'd6, 6'd3));
    clr(6'd3); settle();
    check("R6 own code clears", {irq_req, irq_lvl, irq_id}, 10'd0);

    // R12: edge arrives in the same cycle as the clear write
    irq_in = N'(1) << 2;
    @(posedge clk); @(posedge clk); @(negedge clk);
    clr_we = 1'b1; clr_code = 6'd3;
    @(posedge clk); @(negedge clk);
    clr_we = 1'b0;
    settle();
    check("R12 set wins over clear", {irq_req, irq_lvl, irq_id}, pack(1, 3'd6, 6'd3));
    clr(6'd3); settle();
    check("R12 later clear", {irq_req, irq_lvl, irq_id}, 10'd0);
    irq_in = '0; cfg(2, 2'b01, 3'd0);

    // R7: clear on a level source
    cfg(5, 2'b01, 3'd3);
    irq_in = N'(1) << 5; settle();
    clr(6'd6); settle();
    check("R7 clear ignored on level", {irq_req, irq_lvl, irq_id}, pack(1, 3'd3, 6'd6));
    // R8: priority 0 hides the source
    cfg(5, 2'b01, 3'd0); settle();
    check("R8 level zero disabled", {irq_req, irq_lvl, irq_id}, 10'd0);

    // R10: mask sweep
    cfg(5, 2'b01, 3'd4);
    for (int m = 0; m < 8; m++) begin
      mask_lvl = 3'(m); settle();
      if (4 > m) check("R10 above mask", {irq_req, irq_lvl, irq_id}, pack(1, 3'd4, 6'd6));
      else       check("R10 masked", {irq_req, irq_lvl, irq_id}, 10'd0);
    end
    mask_lvl = 3'd0; glb_en = 1'b0; settle();
    check("R10 global disable", {irq_req, irq_lvl, irq_id}, 10'd0);

    // R11: one-edge latency on gating inputs
    glb_en = 1'b1; settle();
    glb_en = 1'b0;
    check("R11 before edge", {irq_req, irq_lvl, irq_id}, pack(1, 3'd4, 6'd6));
    @(posedge clk); @(negedge clk);
    check("R11 after edge", {irq_req, irq_lvl, irq_id}, 10'd0);
    mask_lvl = 3'd5; glb_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 mask after edge", {irq_req, irq_lvl, irq_id}, 10'd0);
    mask_lvl = 3'd3;
    @(posedge clk); @(negedge clk);
    check("R11 unmask after edge", {irq_req, irq_lvl, irq_id}, pack(1, 3'd4, 6'd6));
    mask_lvl = 3'd0;

    // R13: reconfigure mode only on source 5, others untouched
    cfg(5, 2'b00, 3'd4); settle();
    check("R13 mode replaced", {irq_req, irq_lvl, irq_id}, 10'd0);
    irq_in = '0; settle();
    check("R13 low now active", {irq_req, irq_lvl, irq_id}, pack(1, 3'd4, 6'd6));
    all_off(); settle();

    // R9: exhaustive pattern sweep with ties and a disabled source
    for (int i = 0; i < N; i++)
      cfg(i, 2'b01, (i == N - 1) ? 3'd0 : 3'(((i * 3) % 4) + 1));
    for (int p = 0; p < (1 << N); p++) begin
      logic [2:0] bl;
      logic [5:0] bi;
      bl = 0; bi = 0;
      for (int i = 0; i < N; i++) begin
        logic [2:0] li;
        li = (i == N - 1) ? 3'd0 : 3'(((i * 3) % 4) + 1);
        if (p[i] && li > bl) begin bl = li; bi = 6'(i + 1); end
      end
      irq_in = N'(p); settle();
      check("R9 priority pick", {irq_req, irq_lvl, irq_id},
            (bl != 0) ? pack(1, bl, bi) : 10'd0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule